// File: doc/BRIEF.md
# Cluster Performance Monitor Counter Unit

This block counts activity in a shared processor cluster. It holds a parameterised bank of 32-bit event counters and one 64-bit cycle counter. Each event counter watches one line of a 64-bit event bus. The line is chosen by the event number held in that counter's select register. The counter advances on every clock in which that line is high, provided the global enable and the counter's own enable are both set. Event number 0x11 stands for cycles: a counter that selects it advances on every enabled clock, whatever the bus carries.

Software reaches everything through a simple single-cycle register port. A write takes effect on the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. A read that happens during an edge where `reg_rd` is high also carries out the read's side effect, which clears the overflow status. When a counter wraps from all-ones to zero, it sets a sticky overflow bit. The level interrupt stays high while any overflow bit is set whose interrupt enable is also set.

Register map (word addresses, 7 bits): 0x00 control, 0x01 counter enable, 0x02 interrupt enable, 0x03 overflow status, 0x04/0x05 supported-event bitmap low/high, 0x06/0x07 cycle counter low/high word, 0x20+i event counter i value, 0x40+i event counter i select.

Top module: `cpmu_top`

## Requirements
- R1: After reset every counter, select register, enable bitmap and overflow bit is zero, the global enable is clear and `irq` is low.
- R2: Control register 0x00: bit 0 is the read/write global enable. Bits [15:11] read NUM_CNT. Bits [23:16] read ID_CODE. Bits [31:24] read IMPL_CODE. All other bits read zero.
- R3: In the bitmap registers 0x01, 0x02 and 0x03, bit i is event counter i and bit 31 is the cycle counter. Bits of counters that are not implemented read zero.
- R4: An event counter advances by one on each clock where the global enable is set, its enable bit is set, its selected event number is supported and the selected `evt_in` bit is high. Selecting 0x11, when supported, counts every such enabled clock. An unsupported number never counts.
- R5: While the global enable is clear, no counter advances, even when its own enable bit is set.
- R6: The 64-bit cycle counter advances on every clock where the global enable and bitmap bit 31 are set. Its low word is at 0x06 and its high word at 0x07, and a carry passes from the low word into the high word.
- R7: Software may write any value into any counter. A counter that steps from all-ones to zero sets its overflow bit.
- R8: A read of 0x03 returns the overflow bits and clears them. An overflow that occurs on the same edge stays set. Writes to 0x03 are ignored.
- R9: `irq` is high exactly while some overflow bit is set whose interrupt-enable bit (0x02) is also set.
- R10: Writing 1 to control bit 1 zeroes all event counters, and writing 1 to control bit 2 zeroes the cycle counter. Both act once per write and read back as zero.
- R11: Value and select addresses of counters that are not implemented, and unmapped addresses, read zero. Writes to them change nothing.
- R12: Registers 0x04 and 0x05 read bits [31:0] and [63:32] of the SUPP_EVTS bitmap of supported event numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_in | input | 64 | Event lines, bit n carries event number n |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the unit with three event counters and a supported-event set made of numbers 0 to 3 plus 0x11. This leaves most bitmap bits and the value and select slots from index 3 upward unimplemented, so masking and ignored accesses are easy to observe. Every implemented counter is swept over supported and unsupported event numbers with a different pulse count for each, and the expected count is computed from the pulse count and the supported set. Wrap behaviour of both counter widths is reached by preloading values a few counts below all-ones rather than by counting through the full range.

// File: rtl/cpmu_pkg.sv
package cpmu_pkg;
   localparam int ADDR_W    = 7;
   localparam int DATA_W    = 32;
   localparam int EVT_NUM_W = 6;
   localparam int NUM_EVTS  = 64;
   localparam int CYC_BIT   = 31;

   localparam logic [ADDR_W-1:0] A_CTRL  = 7'h00;
   localparam logic [ADDR_W-1:0] A_CNTEN = 7'h01;
   localparam logic [ADDR_W-1:0] A_INTEN = 7'h02;
   localparam logic [ADDR_W-1:0] A_OVF   = 7'h03;
   localparam logic [ADDR_W-1:0] A_SUPLO = 7'h04;
   localparam logic [ADDR_W-1:0] A_SUPHI = 7'h05;
   localparam logic [ADDR_W-1:0] A_CYCLO = 7'h06;
   localparam logic [ADDR_W-1:0] A_CYCHI = 7'h07;

   localparam logic [1:0] PAGE_MISC = 2'b00;
   localparam logic [1:0] PAGE_VAL  = 2'b01;
   localparam logic [1:0] PAGE_SEL  = 2'b10;

   localparam logic [EVT_NUM_W-1:0] EVT_CYCLES = 6'h11;

   function automatic logic [DATA_W-1:0] impl_mask(input int n);
      logic [DATA_W-1:0] m;
      m = '0;
      m[CYC_BIT] = 1'b1;
      for (int i = 0; i < CYC_BIT; i++)
         if (i < n) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/cpmu_evt_cnt.sv
module cpmu_evt_cnt
   import cpmu_pkg::*;
#(
   parameter logic [NUM_EVTS-1:0] SUPP_EVTS = '1,
   parameter int                  CNT_W     = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 clr,
   input  logic                 val_wr,
   input  logic                 sel_wr,
   input  logic [CNT_W-1:0]     wdata,
   input  logic [NUM_EVTS-1:0]  evt_in,
   output logic [CNT_W-1:0]     value,
   output logic [EVT_NUM_W-1:0] sel,
   output logic                 wrap
);
   logic hit, inc;

   // cycles event ignores the bus; unsupported numbers never hit
   assign hit  = SUPP_EVTS[sel] && ((sel == EVT_CYCLES) || evt_in[sel]);
   assign inc  = en && hit;
   assign wrap = inc && !clr && !val_wr && (value == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
         sel   <= '0;
      end else begin
         if (clr)         value <= '0;
         else if (val_wr) value <= wdata;
         else if (inc)    value <= value + 1'b1;
         if (sel_wr)      sel   <= wdata[EVT_NUM_W-1:0];
      end
   end
endmodule

// File: rtl/cpmu_cyc_cnt.sv
module cpmu_cyc_cnt
   import cpmu_pkg::*;
#(
   parameter int HALF_W = 32,
   localparam int FULL_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              clr,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] wdata,
   output logic [FULL_W-1:0] value,
   output logic              wrap
);
   assign wrap = en && !clr && !wr_lo && !wr_hi && (value == {FULL_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     value <= '0;
      else if (clr)   value <= '0;
      else if (wr_lo) value[HALF_W-1:0] <= wdata;
      else if (wr_hi) value[FULL_W-1:HALF_W] <= wdata;
      else if (en)    value <= value + 1'b1;
   end
endmodule

// File: rtl/cpmu_ovf.sv
module cpmu_ovf
   import cpmu_pkg::*;
#(
   parameter int W = DATA_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] wrap,
   input  logic         rd_clr,
   input  logic [W-1:0] inten,
   output logic [W-1:0] ovf,
   output logic         irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf <= '0;
      else        ovf <= (rd_clr ? '0 : ovf) | wrap;
   end

   assign irq = |(ovf & inten);
endmodule

// File: rtl/cpmu_top.sv
module cpmu_top
   import cpmu_pkg::*;
#(
   parameter int                  NUM_CNT   = 6,
   parameter logic [7:0]          ID_CODE   = 8'h5A,
   parameter logic [7:0]          IMPL_CODE = 8'hC3,
   parameter logic [NUM_EVTS-1:0] SUPP_EVTS = 64'h0000_0000_0002_00FF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_EVTS-1:0] evt_in,
   output logic                irq
);
   localparam logic [DATA_W-1:0] IMPL_MASK = impl_mask(NUM_CNT);
   localparam logic [4:0]        NUM_FLD   = 5'(NUM_CNT);

   if (NUM_CNT < 1 || NUM_CNT > 31) begin : g_bad_num_cnt
      $error("cpmu_top: NUM_CNT must lie in 1..31");
   end
   if (SUPP_EVTS[EVT_CYCLES] == 1'b0) begin : g_note_no_cycles
      $info("cpmu_top: cycles event not in supported set");
   end

   logic [1:0]        page;
   logic [4:0]        idx;
   logic              wr_ctrl, clr_evt, clr_cyc;
   logic              glb_en_q;
   logic [DATA_W-1:0] cnten_q, inten_q, ovf_q, wrap_vec;
   logic [63:0]       cyc_val;
   logic [DATA_W-1:0]    cnt_val [NUM_CNT];
   logic [EVT_NUM_W-1:0] cnt_sel [NUM_CNT];

   assign page    = reg_addr[6:5];
   assign idx     = reg_addr[4:0];
   assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
   assign clr_evt = wr_ctrl && reg_wdata[1];
   assign clr_cyc = wr_ctrl && reg_wdata[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_en_q <= 1'b0;
         cnten_q  <= '0;
         inten_q  <= '0;
      end else if (reg_wr) begin
         if (reg_addr == A_CTRL)  glb_en_q <= reg_wdata[0];
         if (reg_addr == A_CNTEN) cnten_q  <= reg_wdata & IMPL_MASK;
         if (reg_addr == A_INTEN) inten_q  <= reg_wdata & IMPL_MASK;
      end
   end

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      cpmu_evt_cnt #(.SUPP_EVTS(SUPP_EVTS), .CNT_W(DATA_W)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (glb_en_q && cnten_q[i]),
         .clr    (clr_evt),
         .val_wr (reg_wr && (page == PAGE_VAL) && (idx == 5'(i))),
         .sel_wr (reg_wr && (page == PAGE_SEL) && (idx == 5'(i))),
         .wdata  (reg_wdata),
         .evt_in (evt_in),
         .value  (cnt_val[i]),
         .sel    (cnt_sel[i]),
         .wrap   (wrap_vec[i])
      );
   end
   for (genvar j = NUM_CNT; j < CYC_BIT; j++) begin : g_unused
      assign wrap_vec[j] = 1'b0;
   end

   cpmu_cyc_cnt #(.HALF_W(DATA_W)) u_cyc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (glb_en_q && cnten_q[CYC_BIT]),
      .clr   (clr_cyc),
      .wr_lo (reg_wr && (reg_addr == A_CYCLO)),
      .wr_hi (reg_wr && (reg_addr == A_CYCHI)),
      .wdata (reg_wdata),
      .value (cyc_val),
      .wrap  (wrap_vec[CYC_BIT])
   );

   cpmu_ovf #(.W(DATA_W)) u_ovf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrap   (wrap_vec),
      .rd_clr (reg_rd && (reg_addr == A_OVF)),
      .inten  (inten_q),
      .ovf    (ovf_q),
      .irq    (irq)
   );

   always_comb begin
      reg_rdata = '0;
      case (page)
         PAGE_MISC: begin
            case (reg_addr)
               A_CTRL:  reg_rdata = {IMPL_CODE, ID_CODE, NUM_FLD, 10'd0, glb_en_q};
               A_CNTEN: reg_rdata = cnten_q;
               A_INTEN: reg_rdata = inten_q;
               A_OVF:   reg_rdata = ovf_q;
               A_SUPLO: reg_rdata = SUPP_EVTS[31:0];
               A_SUPHI: reg_rdata = SUPP_EVTS[63:32];
               A_CYCLO: reg_rdata = cyc_val[31:0];
               A_CYCHI: reg_rdata = cyc_val[63:32];
               default: reg_rdata = '0;
            endcase
         end
         PAGE_VAL: begin
            for (int i = 0; i < NUM_CNT; i++)
               if (idx == 5'(i)) reg_rdata = cnt_val[i];
         end
         PAGE_SEL: begin
            for (int i = 0; i < NUM_CNT; i++)
               if (idx == 5'(i)) reg_rdata = {{(DATA_W-EVT_NUM_W){1'b0}}, cnt_sel[i]};
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/cpmu_chk.sv
module cpmu_chk
   import cpmu_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              glb_en,
   input logic [63:0]       cyc_val,
   input logic [DATA_W-1:0] ovf_q,
   input logic [DATA_W-1:0] wrap_vec,
   input logic              irq
);
   // R5: with the global enable clear and no bus write, the cycle counter holds
   a_r5_no_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en && !reg_wr) |=> $stable(cyc_val));

   // R7: a wrap reported by any counter shows in the status one edge later
   a_r7_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_vec != '0) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));

   // R8: without a status read, set bits stay set
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd && reg_addr == A_OVF) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

   // R8: a status read leaves only bits that wrapped on that same edge
   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_OVF) |=> ((ovf_q & ~$past(wrap_vec)) == '0));

   // R9: no interrupt without some overflow bit
   a_r9_irq_needs_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q == '0) |-> !irq);
endmodule

bind cpmu_top cpmu_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_rd   (reg_rd),
   .reg_addr (reg_addr),
   .glb_en   (glb_en_q),
   .cyc_val  (cyc_val),
   .ovf_q    (ovf_q),
   .wrap_vec (wrap_vec),
   .irq      (irq)
);

// File: tb/cpmu_top_tb.sv
`timescale 1ns/100ps
module cpmu_top_tb;
   localparam int          NC   = 3;
   localparam logic [63:0] SUPP = 64'h0000_0000_0002_000F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] evt_in = '0;
   logic        irq;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [31:0] rv;

   always #2.5 clk = ~clk;

   cpmu_top #(.NUM_CNT(NC), .ID_CODE(8'hA5), .IMPL_CODE(8'h3C), .SUPP_EVTS(SUPP)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic pulse(input int e, input int k);
      @(negedge clk);
      evt_in[e] = 1'b1;
      repeat (k) @(posedge clk);
      @(negedge clk);
      evt_in = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(7'h01, rv); chk("R1 cnten", rv, 32'h0);
      rd(7'h03, rv); chk("R1 ovf", rv, 32'h0);
      rd(7'h20, rv); chk("R1 cnt0", rv, 32'h0);
      rd(7'h42, rv); chk("R1 sel2", rv, 32'h0);
      rd(7'h06, rv); chk("R1 cyclo", rv, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);

      // R2 control layout
      rd(7'h00, rv); chk("R2 ctrl", rv, {8'h3C, 8'hA5, 5'd3, 11'd0});
      wr(7'h00, 32'hFFFF_FFF9);
      rd(7'h00, rv); chk("R2 ctrl en", rv, {8'h3C, 8'hA5, 5'd3, 11'd1});

      // R3 bitmap masking
      wr(7'h01, 32'hFFFF_FFFF);
      rd(7'h01, rv); chk("R3 cnten mask", rv, 32'h8000_0007);
      wr(7'h02, 32'hFFFF_FFFF);
      rd(7'h02, rv); chk("R3 inten mask", rv, 32'h8000_0007);
      wr(7'h02, 32'h0);

      // R12 supported bitmap
      rd(7'h04, rv); chk("R12 suplo", rv, SUPP[31:0]);
      rd(7'h05, rv); chk("R12 suphi", rv, SUPP[63:32]);

      // R4 sweep: every counter against supported and unsupported numbers
      wr(7'h01, 32'h0000_0007);
      for (int i = 0; i < NC; i++) begin
         for (int e = 0; e < 9; e++) begin
            int ev, k;
            logic [31:0] ex;
            ev = (e < 7) ? e : ((e == 7) ? 32 : 63);
            k  = (e % 5) + 1 + i;
            wr(7'h20 + 7'(i), 32'h0);
            wr(7'h40 + 7'(i), 32'(ev));
            pulse(ev, k);
            ex = SUPP[ev] ? 32'(k) : 32'h0;
            rd(7'h20 + 7'(i), rv);
            chk($sformatf("R4 cnt%0d evt%0d", i, ev), rv, ex);
         end
      end
      rd(7'h41, rv); chk("R4 sel readback", rv, 32'd63);

      // R4 cycles event: enabled at E0, idle 4, disabled at E5 -> 5 counts
      wr(7'h01, 32'h0);
      wr(7'h20, 32'h0);
      wr(7'h40, 32'h11);
      wr(7'h01, 32'h1);
      idle(4);
      wr(7'h01, 32'h0);
      rd(7'h20, rv); chk("R4 cycles event", rv, 32'd5);

      // R6 cycle counter: idle 6 -> 7 counts
      wr(7'h06, 32'h0); wr(7'h07, 32'h0);
      wr(7'h01, 32'h8000_0000);
      idle(6);
      wr(7'h01, 32'h0);
      rd(7'h06, rv); chk("R6 cyc count", rv, 32'd7);
      wr(7'h06, 32'hFFFF_FFFF); wr(7'h07, 32'h0);
      wr(7'h01, 32'h8000_0000);
      wr(7'h01, 32'h0);
      rd(7'h06, rv); chk("R6 carry lo", rv, 32'h0);
      rd(7'h07, rv); chk("R6 carry hi", rv, 32'h1);

      // R5 global enable gating
      wr(7'h00, 32'h0);
      wr(7'h20, 32'h0); wr(7'h40, 32'h0);
      wr(7'h06, 32'h0);
      wr(7'h01, 32'h8000_0007);
      pulse(0, 4);
      idle(3);
      rd(7'h20, rv); chk("R5 evt gated", rv, 32'h0);
      rd(7'h06, rv); chk("R5 cyc gated", rv, 32'h0);

      // R7/R9 event counter wrap with interrupt enabled
      wr(7'h01, 32'h1);
      wr(7'h00, 32'h1);
      wr(7'h02, 32'h1);
      wr(7'h20, 32'hFFFF_FFFD);
      pulse(0, 2);
      chk("R9 irq before wrap", {31'b0, irq}, 32'h0);
      pulse(0, 1);
      chk("R9 irq after wrap", {31'b0, irq}, 32'h1);
      rd(7'h20, rv); chk("R7 wrapped value", rv, 32'h0);
      wr(7'h03, 32'h0);
      chk("R8 write ignored", {31'b0, irq}, 32'h1);
      rd(7'h03, rv); chk("R8 ovf read", rv, 32'h1);
      chk("R9 irq cleared", {31'b0, irq}, 32'h0);
      rd(7'h03, rv); chk("R8 ovf cleared", rv, 32'h0);

      // R9 wrap with interrupt disabled
      wr(7'h02, 32'h0);
      wr(7'h20, 32'hFFFF_FFFF);
      pulse(0, 1);
      chk("R9 irq masked", {31'b0, irq}, 32'h0);
      rd(7'h03, rv); chk("R9 ovf still set", rv, 32'h1);

      // R7 cycle counter wrap: idle 1 -> 2 counts
      wr(7'h01, 32'h0);
      wr(7'h06, 32'hFFFF_FFFE); wr(7'h07, 32'hFFFF_FFFF);
      wr(7'h01, 32'h8000_0000);
      idle(1);
      wr(7'h01, 32'h0);
      rd(7'h06, rv); chk("R7 cyc wrap lo", rv, 32'h0);
      rd(7'h07, rv); chk("R7 cyc wrap hi", rv, 32'h0);
      rd(7'h03, rv); chk("R7 cyc ovf bit31", rv, 32'h8000_0000);

      // R10 reset pulses
      wr(7'h21, 32'd123); wr(7'h22, 32'd9); wr(7'h06, 32'd77);
      wr(7'h00, 32'h3);
      rd(7'h21, rv); chk("R10 evt reset cnt1", rv, 32'h0);
      rd(7'h22, rv); chk("R10 evt reset cnt2", rv, 32'h0);
      rd(7'h06, rv); chk("R10 cyc kept", rv, 32'd77);
      rd(7'h00, rv); chk("R10 pulse bits read 0", rv[2:0], 32'h1);
      wr(7'h00, 32'h5);
      rd(7'h06, rv); chk("R10 cyc reset", rv, 32'h0);

      // R11 unimplemented slots
      wr(7'h20, 32'h55);
      wr(7'h23, 32'hDEAD_BEEF);
      wr(7'h43, 32'h2);
      wr(7'h08, 32'h1234);
      rd(7'h23, rv); chk("R11 val3", rv, 32'h0);
      rd(7'h43, rv); chk("R11 sel3", rv, 32'h0);
      rd(7'h08, rv); chk("R11 unmapped", rv, 32'h0);
      rd(7'h20, rv); chk("R11 cnt0 undisturbed", rv, 32'h55);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule